// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

The block is a 32-line general-purpose I/O port controlled through a simple word-wide register interface. Software picks each line's direction, its drive style (push-pull or open-drain) and an output value. It can also allow or block the sampled pin level from reaching the data register. Pad inputs are resynchronised to the block clock before any use. The block drives an output value and an output enable for each pad.

Register bits are numbered in the reverse order of line numbers: line n sits at register bit 31−n in every register. A parameter lists lines that can never drive. Their direction bits stay 0 whatever software writes. Interrupt logic, bus protocol adaptation and byte-lane swapping are handled by neighbouring blocks.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low, all four registers clear to 0, every `pad_oe` bit is 0 and `rdata` is 0. After reset all lines are inputs, open-drain is off and all input buffers are disabled.
- R2: Byte addresses decode as direction 0x00, drive style 0x04, data 0x08 and input enable 0x18. A read of any other address returns 0, and a write to any other address changes no register and no pad output.
- R3: Line n maps to register bit 31−n in every register and on every pad vector (`pad_in`, `pad_out` and `pad_oe` are indexed by line number).
- R4: A direction bit of 1 makes the line an output and 0 makes it an input. On a push-pull output line (drive-style bit 0), `pad_oe` is 1 and `pad_out` equals the latch bit. The pad outputs change only after a register write.
- R5: For an input line, the data register reads the synchronised pin level only while that line's input-enable bit is 1. Otherwise the bit reads 0.
- R6: The lines set in the parameter `IN_ONLY_LINES` (line-indexed, default lines 28 to 31) always read back 0 in the direction register and never assert `pad_oe`. Writes to their direction bits are ignored.
- R7: For an output line, the data register reads back the output latch, whatever the pin level is.
- R8: A data-register write loads the latch for all 32 bits, including bits of input lines. The stored value appears on a line once that line becomes an output.
- R9: On an output line whose drive-style bit is 1, a latch value of 0 drives the pad low with `pad_oe` set. A latch value of 1 releases the pad with `pad_oe` cleared.
- R10: A pin change passes through two flops. A read that samples on the first or second rising edge after the change returns the old level, and a read that samples on the third edge returns the new level.
- R11: `rdata` is registered. The edge that samples `re` high loads the selected register as it stood before that edge, so a read and a write to the same register in one cycle return the old contents. An edge with `re` low loads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data, register bit order |
| we | input | 1 | Write strobe, one cycle per write |
| re | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid the cycle after `re` |
| pad_in | input | 32 | Raw pad levels, indexed by line |
| pad_out | output | 32 | Pad output values, indexed by line |
| pad_oe | output | 32 | Pad output enables, indexed by line |

## Verification
A register write and a read of that same register can fall in the same clock cycle. This matters most for the direction and data registers, because their read-back merges latch and pin state. The bench holds `we` and `re` together for one cycle on the direction register. It expects the pre-write contents in `rdata`, then expects the new contents on the next read. A second overlap is a pin edge that arrives while reads are already streaming. The bench reads on every cycle and judges on which edge the new level first appears.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int LINES = 32,
  parameter int AW = 8,
  parameter logic [LINES-1:0] IN_ONLY_LINES = 32'hF000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [LINES-1:0] wdata,
  input  logic             we,
  input  logic             re,
  output logic [LINES-1:0] rdata,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe
);

  localparam logic [AW-1:0] OFS_DIR = AW'(8'h00);
  localparam logic [AW-1:0] OFS_ODR = AW'(8'h04);
  localparam logic [AW-1:0] OFS_DAT = AW'(8'h08);
  localparam logic [AW-1:0] OFS_IBE = AW'(8'h18);

  logic [LINES-1:0] dir_q, odr_q, lat_q, ibe_q;
  logic [LINES-1:0] meta_q, sync_q;
  logic [LINES-1:0] fixed_in, pin_bits, dat_view, drive_en, drive_val;
  logic [LINES-1:0] rd_mux, rd_q;

  for (genvar n = 0; n < LINES; n++) begin : g_line
    assign fixed_in[LINES-1-n] = IN_ONLY_LINES[n];
    assign pin_bits[LINES-1-n] = sync_q[n];
    assign pad_oe[n]           = drive_en[LINES-1-n];
    assign pad_out[n]          = drive_val[LINES-1-n];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      lat_q <= '0;
      ibe_q <= '0;
    end else if (we) begin
      case (addr)
        OFS_DIR: dir_q <= wdata & ~fixed_in;
        OFS_ODR: odr_q <= wdata;
        OFS_DAT: lat_q <= wdata;
        OFS_IBE: ibe_q <= wdata;
        default: ;
      endcase
    end
  end

  assign dat_view  = (lat_q & dir_q) | (pin_bits & ibe_q & ~dir_q);
  assign drive_en  = dir_q & ~(odr_q & lat_q);
  assign drive_val = lat_q & ~odr_q;

  always_comb begin
    case (addr)
      OFS_DIR: rd_mux = dir_q;
      OFS_ODR: rd_mux = odr_q;
      OFS_DAT: rd_mux = dat_view;
      OFS_IBE: rd_mux = ibe_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= re ? rd_mux : '0;
  end

  assign rdata = rd_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && rdata == '0));

  // R6
  input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & IN_ONLY_LINES) == '0);

  // R4
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(pad_oe) && $stable(pad_out)));

  // R2
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != OFS_DIR && addr != OFS_ODR && addr != OFS_DAT && addr != OFS_IBE)
      |=> ($stable(pad_oe) && $stable(pad_out)));

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> rdata == '0);

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int total = 0;
  int bad = 0;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #5 clk = ~clk;

  localparam logic [7:0] A_DIR = 8'h00, A_ODR = 8'h04, A_DAT = 8'h08, A_IBE = 8'h18;

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 pad_oe", pad_oe, 32'h0);
    rd(A_DIR, v); check("R1 dir", v, 32'h0);
    rd(A_ODR, v); check("R1 odr", v, 32'h0);
    rd(A_DAT, v); check("R1 dat", v, 32'h0);
    rd(A_IBE, v); check("R1 ibe", v, 32'h0);
  endtask

  task automatic t_direction();
    logic [31:0] v;
    wr(A_DIR, 32'h8000_0000);
    check("R3 line0 from bit31", pad_oe, 32'h0000_0001);
    wr(A_DIR, 32'hFFFF_FFFF);
    rd(A_DIR, v); check("R6 fixed inputs", v, 32'hFFFF_FFF0);
    check("R4 R6 pad_oe", pad_oe, 32'h0FFF_FFFF);
  endtask

  task automatic t_data_out();
    logic [31:0] v;
    wr(A_DAT, 32'h1234_5678);
    check("R4 pad_out", pad_out & pad_oe, rev(32'h1234_5670));
    rd(A_DAT, v); check("R7 latch readback", v, 32'h1234_5670);
  endtask

  task automatic t_input_gate();
    logic [31:0] v;
    pad_in = 32'hA000_0000 | 32'h0F00_0000;
    repeat (3) @(negedge clk);
    rd(A_DAT, v); check("R5 gated off", v, 32'h1234_5670);
    wr(A_IBE, 32'hFFFF_FFFF);
    rd(A_IBE, v); check("R5 ibe readback", v, 32'hFFFF_FFFF);
    rd(A_DAT, v); check("R5 gated on, R7 outputs ignore pins", v, 32'h1234_5675);
  endtask

  task automatic t_sync();
    wr(A_DIR, 32'h0);
    pad_in = 32'h0;
    repeat (3) @(negedge clk);
    addr = A_DAT; re = 1'b1; pad_in = 32'h0000_0001;
    @(negedge clk); check("R10 edge1 old", rdata, 32'h0);
    @(negedge clk); check("R10 edge2 old", rdata, 32'h0);
    @(negedge clk); check("R10 edge3 new", rdata, 32'h8000_0000);
    re = 1'b0;
    pad_in = 32'h0;
  endtask

  task automatic t_open_drain();
    wr(A_DIR, 32'hFFFF_FFF0);
    wr(A_ODR, 32'hFFFF_FFFF);
    wr(A_DAT, 32'hFFFF_0000);
    check("R9 oe", pad_oe, 32'h0FFF_0000);
    check("R9 drive low", pad_out & pad_oe, 32'h0);
    wr(A_ODR, 32'h0);
  endtask

  task automatic t_latch_hidden();
    logic [31:0] v;
    wr(A_DIR, 32'h0);
    wr(A_IBE, 32'h0);
    wr(A_DAT, 32'hCAFE_BABE);
    check("R8 no drive while input", pad_oe, 32'h0);
    rd(A_DAT, v); check("R8 input reads gated", v, 32'h0);
    wr(A_DIR, 32'hFFFF_FFFF);
    rd(A_DAT, v); check("R8 stored latch", v, 32'hCAFE_BAB0);
    check("R8 pad_out", pad_out & pad_oe, rev(32'hCAFE_BAB0));
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    logic [31:0] oe0, out0;
    oe0 = pad_oe; out0 = pad_out;
    wr(8'h0C, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'h01, 32'h0);
    check("R2 pad_oe unchanged", pad_oe, oe0);
    check("R2 pad_out unchanged", pad_out, out0);
    rd(A_DIR, v); check("R2 dir unchanged", v, 32'hFFFF_FFF0);
    rd(8'h0C, v); check("R2 unmapped read", v, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    @(negedge clk);
    addr = A_DIR; wdata = 32'h0000_0F00; we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    check("R11 same-cycle old value", rdata, 32'hFFFF_FFF0);
    @(negedge clk);
    check("R11 idle zero", rdata, 32'h0);
    rd(A_DIR, v); check("R11 new value", v, 32'h0000_0F00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", rdata, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_data_out();
    t_input_gate();
    t_sync();
    t_open_drain();
    t_latch_hidden();
    t_unmapped();
    t_collision();
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule